// File: doc/BRIEF.md
# Bidirectional Bubbling Shift Register

This block is a small register slice of shifting bits plus a few side bits that never shift. Each shifting bit can copy the bit next to it on the lower-index side (an UP move) or the bit next to it on the higher-index side (a DOWN move). The end bits take their new values from two dedicated fill inputs. A per-slice enable line gates every move. When the enable is low, the commands are ignored. A parallel load writes all bits at once and wins over any move in the same cycle.

Two operating modes are selected by a mode input. In stacking mode the controller must issue UP and DOWN in separate cycles. A cycle that asserts both is refused: the register holds and a one-cycle error flag is raised. In bubbling mode both commands may arrive together. Every bit then computes its next value from a snapshot of all bits taken before the update, so no bit sees a neighbour that has already moved in that cycle. A bit only changes when it is primed, meaning it differs from the neighbour it would copy. When both moves are requested and the two neighbours disagree, the lower neighbour wins.

Top module: `bubble_shift_reg`

## Requirements
- R1: An active-low asynchronous reset clears all shifting bits, all side bits and the error flag to 0.
- R2: When load_en is 1, q takes load_data and aux_q takes aux_load_data on the next clock edge, whatever the other inputs are.
- R3: With shift_en=1 and only up_cmd set, q[i] takes the old q[i-1] for i>0, and q[0] takes fill_low.
- R4: With shift_en=1 and only down_cmd set, q[i] takes the old q[i+1] for i<WIDTH-1, and q[WIDTH-1] takes fill_high.
- R5: With shift_en=0 and no load, q holds for any combination of up_cmd, down_cmd and bubble_mode.
- R6: With bubble_mode=0 (stacking), both commands set and no load, q holds and conflict_err is 1 in the following cycle. In every other cycle conflict_err is 0 in the following cycle.
- R7: With bubble_mode=1, shift_en=1 and both commands set, each bit's next value comes from the old values. If the lower and upper sources agree, the bit takes that common value. If they differ, it takes the lower source (old q[i-1], or fill_low for bit 0).
- R8: aux_q changes only through a parallel load. UP and DOWN never alter it.
- R9: With neither command set and no load, q holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Parallel load strobe, highest priority |
| load_data | input | WIDTH | Parallel value for the shifting bits |
| aux_load_data | input | AUX_W | Parallel value for the side bits |
| up_cmd | input | 1 | Move request from the lower-index neighbour |
| down_cmd | input | 1 | Move request from the higher-index neighbour |
| shift_en | input | 1 | Slice enable for moves; 0 blocks UP and DOWN |
| bubble_mode | input | 1 | 1 = bubbling (both commands allowed), 0 = stacking |
| fill_low | input | 1 | Value entering bit 0 on an UP move |
| fill_high | input | 1 | Value entering bit WIDTH-1 on a DOWN move |
| q | output | WIDTH | Shifting bits |
| aux_q | output | AUX_W | Side bits that never shift |
| conflict_err | output | 1 | Stacking-mode double command seen in the previous cycle |

## Verification
The bench builds the block with its defaults, eight shifting bits and two side bits. This width is small enough that the directed patterns can place a primed and an unprimed bit next to each end fill and next to interior bits in the same test. A random phase of several hundred cycles mixes single, double, inhibited and load cycles in both modes and compares every cycle against a snapshot model. This covers the orderings in which a bit's neighbour moves in the same step.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_UP   = 2'd1,
        MV_DOWN = 2'd2,
        MV_BOTH = 2'd3
    } move_e;

endpackage

// File: rtl/bubble_cmd_decode.sv
module bubble_cmd_decode
    import bsr_pkg::*;
(
    input  logic  up_cmd,
    input  logic  down_cmd,
    input  logic  shift_en,
    input  logic  bubble_mode,
    output move_e move,
    output logic  conflict
);

    logic both;

    always_comb begin
        both     = up_cmd && down_cmd;
        // stacking mode refuses a double command regardless of enable
        conflict = both && !bubble_mode;
        move     = MV_HOLD;
        if (shift_en && !conflict) begin
            unique case ({up_cmd, down_cmd})
                2'b10:   move = MV_UP;
                2'b01:   move = MV_DOWN;
                2'b11:   move = MV_BOTH;
                default: move = MV_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/bubble_cell.sv
module bubble_cell
    import bsr_pkg::*;
(
    input  logic  own_q,
    input  logic  lower_src,
    input  logic  upper_src,
    input  move_e move,
    output logic  own_d
);

    logic primed_lo;
    logic primed_hi;
    logic toggle;

    always_comb begin
        primed_lo = own_q ^ lower_src;
        primed_hi = own_q ^ upper_src;
        unique case (move)
            MV_UP:   toggle = primed_lo;
            MV_DOWN: toggle = primed_hi;
            // both: equal sources -> common value; differing -> lower wins
            MV_BOTH: toggle = (lower_src == upper_src) ? primed_hi : primed_lo;
            default: toggle = 1'b0;
        endcase
        own_d = own_q ^ toggle;
    end

endmodule

// File: rtl/bubble_shift_reg.sv
module bubble_shift_reg
    import bsr_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int AUX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_data,
    input  logic [AUX_W-1:0] aux_load_data,
    input  logic             up_cmd,
    input  logic             down_cmd,
    input  logic             shift_en,
    input  logic             bubble_mode,
    input  logic             fill_low,
    input  logic             fill_high,
    output logic [WIDTH-1:0] q,
    output logic [AUX_W-1:0] aux_q,
    output logic             conflict_err
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
        logic [AUX_W-1:0] aux;
        logic             conflict;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    move_e            move;
    logic             conflict_now;
    logic [WIDTH-1:0] moved;

    bubble_cmd_decode u_decode (
        .up_cmd      (up_cmd),
        .down_cmd    (down_cmd),
        .shift_en    (shift_en),
        .bubble_mode (bubble_mode),
        .move        (move),
        .conflict    (conflict_now)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic lo_src;
        logic hi_src;
        if (i == 0) begin : g_lo_end
            assign lo_src = fill_low;
        end else begin : g_lo_mid
            assign lo_src = st_q.bits[i-1];
        end
        if (i == TOP) begin : g_hi_end
            assign hi_src = fill_high;
        end else begin : g_hi_mid
            assign hi_src = st_q.bits[i+1];
        end
        bubble_cell u_cell (
            .own_q     (st_q.bits[i]),
            .lower_src (lo_src),
            .upper_src (hi_src),
            .move      (move),
            .own_d     (moved[i])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.conflict = conflict_now && !load_en;
        if (load_en) begin
            st_d.bits = load_data;
            st_d.aux  = aux_load_data;
        end else begin
            st_d.bits = moved;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q            = st_q.bits;
    assign aux_q        = st_q.aux;
    assign conflict_err = st_q.conflict;

endmodule

// File: rtl/bubble_shift_reg_chk.sv
module bubble_shift_reg_chk #(
    parameter int WIDTH = 8,
    parameter int AUX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_en,
    input logic [WIDTH-1:0] load_data,
    input logic [AUX_W-1:0] aux_load_data,
    input logic             up_cmd,
    input logic             down_cmd,
    input logic             shift_en,
    input logic             bubble_mode,
    input logic             fill_low,
    input logic             fill_high,
    input logic [WIDTH-1:0] q,
    input logic [AUX_W-1:0] aux_q,
    input logic             conflict_err
);

    // R2
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (q == $past(load_data)) && (aux_q == $past(aux_load_data)));

    // R3
    up_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && shift_en && up_cmd && !down_cmd)
        |=> q == {$past(q[WIDTH-2:0]), $past(fill_low)});

    // R4
    down_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && shift_en && down_cmd && !up_cmd)
        |=> q == {$past(fill_high), $past(q[WIDTH-1:1])});

    // R5
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !shift_en) |=> $stable(q));

    // R6
    stack_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !bubble_mode && up_cmd && down_cmd) |=> conflict_err && $stable(q));

    // R6
    no_false_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!load_en && !bubble_mode && up_cmd && down_cmd) |=> !conflict_err);

    // R8
    aux_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(aux_q));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !up_cmd && !down_cmd) |=> $stable(q));

endmodule

bind bubble_shift_reg bubble_shift_reg_chk #(.WIDTH(WIDTH), .AUX_W(AUX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_en       (load_en),
    .load_data     (load_data),
    .aux_load_data (aux_load_data),
    .up_cmd        (up_cmd),
    .down_cmd      (down_cmd),
    .shift_en      (shift_en),
    .bubble_mode   (bubble_mode),
    .fill_low      (fill_low),
    .fill_high     (fill_high),
    .q             (q),
    .aux_q         (aux_q),
    .conflict_err  (conflict_err)
);

// File: tb/bubble_shift_reg_test.sv
module bubble_shift_reg_test;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en = 1'b0;
    logic [W-1:0]  load_data = '0;
    logic [AW-1:0] aux_load_data = '0;
    logic          up_cmd = 1'b0;
    logic          down_cmd = 1'b0;
    logic          shift_en = 1'b0;
    logic          bubble_mode = 1'b0;
    logic          fill_low = 1'b0;
    logic          fill_high = 1'b0;
    logic [W-1:0]  q;
    logic [AW-1:0] aux_q;
    logic          conflict_err;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    logic [W-1:0]  exp_q;
    logic [AW-1:0] exp_aux;
    logic          exp_flag;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bubble_shift_reg #(.WIDTH(W), .AUX_W(AW)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_en       (load_en),
        .load_data     (load_data),
        .aux_load_data (aux_load_data),
        .up_cmd        (up_cmd),
        .down_cmd      (down_cmd),
        .shift_en      (shift_en),
        .bubble_mode   (bubble_mode),
        .fill_low      (fill_low),
        .fill_high     (fill_high),
        .q             (q),
        .aux_q         (aux_q),
        .conflict_err  (conflict_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model built from R2..R9
    task automatic model_step();
        logic [W-1:0] nq;
        logic lo;
        logic hi;
        nq = exp_q;
        exp_flag = !load_en && !bubble_mode && up_cmd && down_cmd;
        if (load_en) begin
            nq = load_data;
            exp_aux = aux_load_data;
        end else if (shift_en && !exp_flag) begin
            for (int i = 0; i < W; i++) begin
                lo = (i == 0) ? fill_low : exp_q[i-1];
                hi = (i == W-1) ? fill_high : exp_q[i+1];
                if (up_cmd && down_cmd) nq[i] = (lo == hi) ? hi : lo;
                else if (up_cmd) nq[i] = lo;
                else if (down_cmd) nq[i] = hi;
            end
        end
        exp_q = nq;
    endtask

    // inputs change at negedge, results sampled at the next negedge
    task automatic step(input string req, input logic ld, input logic [W-1:0] ldv,
                        input logic [AW-1:0] av, input logic up, input logic dn,
                        input logic en, input logic md, input logic fl, input logic fh);
        load_en = ld; load_data = ldv; aux_load_data = av;
        up_cmd = up; down_cmd = dn; shift_en = en; bubble_mode = md;
        fill_low = fl; fill_high = fh;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check({req, " q"}, 32'(q), 32'(exp_q));
        check({req, " aux"}, 32'(aux_q), 32'(exp_aux));
        check({req, " flag"}, 32'(conflict_err), 32'(exp_flag));
    endtask

    task automatic preload(input logic [W-1:0] v, input logic [AW-1:0] a);
        step("R2", 1'b1, v, a, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        exp_q = '0; exp_aux = '0; exp_flag = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 q", 32'(q), 32'h0);
        check("R1 aux", 32'(aux_q), 32'h0);
        check("R1 flag", 32'(conflict_err), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_load();
        preload(8'hA5, 2'b10);
        check("R2 direct", 32'(q), 32'hA5);
        preload(8'h3C, 2'b01);
    endtask

    task automatic t_up();
        preload(8'b0110_1001, 2'b11);
        step("R3", 1'b0, '0, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R3 direct", 32'(q), 32'b1101_0011);
        step("R3", 1'b0, '0, '0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R3 direct", 32'(q), 32'b1010_0110);
    endtask

    task automatic t_down();
        preload(8'b0110_1001, 2'b00);
        step("R4", 1'b0, '0, '0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R4 direct", 32'(q), 32'b1011_0100);
        step("R4", 1'b0, '0, '0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R4 direct", 32'(q), 32'b0101_1010);
    endtask

    task automatic t_inhibit();
        preload(8'hC3, 2'b01);
        step("R5", 1'b0, '0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step("R5", 1'b0, '0, '0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        step("R5", 1'b0, '0, '0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R5 direct", 32'(q), 32'hC3);
    endtask

    task automatic t_stack_conflict();
        preload(8'h5A, 2'b10);
        step("R6", 1'b0, '0, '0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R6 held", 32'(q), 32'h5A);
        check("R6 raised", 32'(conflict_err), 32'h1);
        step("R6", 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R6 cleared", 32'(conflict_err), 32'h0);
    endtask

    task automatic t_bubble_both();
        // old 0110_1001, fill_low=1, fill_high=0: each bit takes lower source
        preload(8'b0110_1001, 2'b00);
        step("R7", 1'b0, '0, '0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R7 direct", 32'(q), 32'b1101_0011);
        preload(8'hFF, 2'b00);
        step("R7", 1'b0, '0, '0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R7 direct", 32'(q), 32'hFE);
    endtask

    task automatic t_aux_idle();
        preload(8'h81, 2'b11);
        step("R9", 1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R9 direct", 32'(q), 32'h81);
        step("R8", 1'b0, '0, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        step("R8", 1'b0, '0, '0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R8 direct", 32'(aux_q), 32'h3);
    endtask

    task automatic t_random();
        for (int n = 0; n < 600; n++) begin
            automatic logic [9:0] r = 10'($urandom);
            step("R7 random", (r[3:0] == 4'd0), W'($urandom), AW'($urandom),
                 r[4], r[5], (r[7:6] != 2'b00), r[8], r[9], r[0]);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_load();
        t_up();
        t_down();
        t_inhibit();
        t_stack_conflict();
        t_bubble_both();
        t_aux_idle();
        t_random();
        finish_run();
    end

endmodule